// File: doc/BRIEF.md
# Multiplex Section BIP-24 Parity Engine

This block sits on the transmit or receive byte stream of an STM-1 frame, ahead of any scrambler. It keeps three 8-bit even-parity accumulators, one per column phase (column index modulo 3), and folds into them every byte of the frame except the 3 x 9 corner that holds the regenerator-section overhead. When the last byte of a frame passes, the three sums are latched as the held result for that frame.

In generate mode the held result of frame n replaces the three multiplex-section parity bytes of frame n+1, and the replaced values are what that frame's own accumulation sees. In check mode the stream passes through untouched. The three received parity bytes are compared bit by bit with the held result, and the number of differing bits (0 to 24) is presented with a one-cycle strobe. That number is what a receiver returns as its remote error indication.

The stream is row-major: 9 rows of 270 bytes, with rows and columns numbered from zero. A frame-start strobe marks row 0, column 0, and a valid strobe qualifies each byte. Every output is registered one cycle after its input byte.

Top module: `ms_bip24_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `dout_vld`, `err_stb` and `err_cnt` are all zero.
- R2: Bytes in rows 0 to 2, columns 0 to 8 are excluded from the parity. Every other byte is included, row 3 among them.
- R3: Accumulator k (k = 0, 1, 2) is the bitwise XOR (even parity) of every included byte whose column index modulo 3 equals k.
- R4: With `chk_mode` = 0 (generate), once a complete frame has been seen, row 4 columns 0, 1 and 2 of the following frame are output as held bytes 0, 1 and 2 of the previous frame. Every other byte leaves `dout` unchanged. `dout`/`dout_vld` follow `din`/`vld` one cycle later.
- R5: In generate mode, the replaced parity bytes enter the current frame's accumulation with their new values.
- R6: Until one complete frame (frame-start plus 2430 valid bytes) has passed after reset, no byte is replaced and `err_stb` stays low.
- R7: With `chk_mode` = 1 (check), `dout` equals `din` of the previous valid cycle. One cycle after the third parity byte (row 4, column 2) is presented, `err_stb` pulses for one cycle and `err_cnt` holds the number of bits, out of 24, in which the three received parity bytes differ from the held result. Bit b of byte k is compared with bit b of held byte k.
- R8: Valid bytes that arrive before the first frame-start pass unchanged and affect no state. When `vld` is low, the frame position does not advance and `dout_vld` is low one cycle later.
- R9: A frame-start in the middle of a frame restarts the position and the accumulation. The held result from the last complete frame is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_mode | input | 1 | 0 = generate and insert, 1 = check received parity |
| sof | input | 1 | Marks the byte at row 0, column 0 (qualified by vld) |
| vld | input | 1 | Input byte valid |
| din | input | 8 | Input byte |
| dout | output | 8 | Output byte, registered |
| dout_vld | output | 1 | Output byte valid, registered |
| err_cnt | output | 5 | Mismatched parity bits of the last checked frame |
| err_stb | output | 1 | One-cycle strobe marking a new err_cnt |

## Verification
The bench builds every frame from a seed and computes the expected stream, the three lane sums and the bit-mismatch count from the requirements alone. It compares each output byte. Frames with idle gaps show whether the position wrongly advances on an invalid cycle, which would shift every later parity position. A truncated frame followed by a fresh frame-start catches a design that latches a partial sum or loses the older held result. A mode switch, mismatch masks of 0, 1, 6 and 24 bits, and a check-mode frame straight after reset catch a design that drops the replaced values from its own sum, includes the overhead corner or row 3 wrongly, miscounts the bits, or reports a result before a full frame has passed.

// File: rtl/msb_pkg.sv
package msb_pkg;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } msb_mode_e;

    typedef enum logic [1:0] {
        SLOT_SKIP = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_PAR  = 2'd2
    } slot_e;

endpackage

// File: rtl/msb_frame_pos.sv
module msb_frame_pos
    import msb_pkg::*;
#(
    parameter int NCOL    = 270,
    parameter int NROW    = 9,
    parameter int OH_ROWS = 3,
    parameter int OH_COLS = 9,
    parameter int PAR_ROW = 4,
    parameter int NLANE   = 3,
    localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          vld,
    output logic          act,
    output slot_e         slot,
    output logic [LW-1:0] lane,
    output logic          frame_end
);

    localparam int CW = $clog2(NCOL);
    localparam int RW = $clog2(NROW);
    localparam logic [CW-1:0] COL_LAST = CW'(NCOL - 1);
    localparam logic [CW-1:0] COL_OH   = CW'(OH_COLS);
    localparam logic [CW-1:0] COL_NL   = CW'(NLANE);
    localparam logic [RW-1:0] ROW_LAST = RW'(NROW - 1);
    localparam logic [RW-1:0] ROW_OH   = RW'(OH_ROWS);
    localparam logic [RW-1:0] ROW_PAR  = RW'(PAR_ROW);
    localparam logic [LW-1:0] PH_LAST  = LW'(NLANE - 1);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [LW-1:0] ph;
        logic          sync;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [CW-1:0] cur_col;
    logic [RW-1:0] cur_row;
    logic [LW-1:0] cur_ph;

    always_comb begin
        pos_d   = pos_q;
        cur_col = sof ? '0 : pos_q.col;
        cur_row = sof ? '0 : pos_q.row;
        cur_ph  = sof ? '0 : pos_q.ph;
        act     = vld && (sof || pos_q.sync);
        lane    = cur_ph;

        if (!act) begin
            slot = SLOT_SKIP;
        end else if ((cur_row < ROW_OH) && (cur_col < COL_OH)) begin
            slot = SLOT_SKIP;
        end else if ((cur_row == ROW_PAR) && (cur_col < COL_NL)) begin
            slot = SLOT_PAR;
        end else begin
            slot = SLOT_DATA;
        end

        frame_end = act && (cur_row == ROW_LAST) && (cur_col == COL_LAST);

        if (act) begin
            pos_d.sync = 1'b1;
            if (cur_col == COL_LAST) begin
                pos_d.col = '0;
                pos_d.ph  = '0;
                pos_d.row = (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
            end else begin
                pos_d.col = cur_col + 1'b1;
                pos_d.ph  = (cur_ph == PH_LAST) ? '0 : cur_ph + 1'b1;
                pos_d.row = cur_row;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R8: an invalid cycle leaves the frame position where it was
    a_r8_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> ($stable(pos_q.col) && $stable(pos_q.row)));

    // R3: the phase counter agrees with the column at the start of each row
    a_r3_lane_row_start: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (cur_col == '0)) |-> (lane == '0));

endmodule

// File: rtl/msb_accum.sv
module msb_accum #(
    parameter int W     = 8,
    parameter int NLANE = 3,
    localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      take,
    input  logic [LW-1:0]             lane,
    input  logic [W-1:0]              din,
    input  logic                      fin,
    output logic [NLANE-1:0][W-1:0]   held,
    output logic                      held_ok
);

    typedef struct packed {
        logic [NLANE-1:0][W-1:0] acc;
        logic [NLANE-1:0][W-1:0] res;
        logic                    ok;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [NLANE-1:0][W-1:0] nxt;

    always_comb begin
        acc_d = acc_q;
        nxt   = clr ? '0 : acc_q.acc;
        for (int i = 0; i < NLANE; i++) begin
            if (take && (lane == LW'(i))) nxt[i] = nxt[i] ^ din;
        end
        if (fin) begin
            acc_d.res = nxt;
            acc_d.acc = '0;
            acc_d.ok  = 1'b1;
        end else begin
            acc_d.acc = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign held    = acc_q.res;
    assign held_ok = acc_q.ok;

    // R6: once a full frame has been latched the result stays usable
    a_r6_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        held_ok |=> held_ok);

    // R9: the held result only moves at a complete frame's last byte
    a_r9_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(held));

endmodule

// File: rtl/msb_errcnt.sv
module msb_errcnt #(
    parameter int W     = 8,
    parameter int NLANE = 3,
    localparam int LW   = (NLANE > 1) ? $clog2(NLANE) : 1,
    localparam int CNTW = $clog2(W * NLANE + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [LW-1:0]   lane,
    input  logic [W-1:0]    rx_b,
    input  logic [W-1:0]    exp_b,
    output logic [CNTW-1:0] err_cnt,
    output logic            err_stb
);

    localparam logic [LW-1:0]   LANE_LAST = LW'(NLANE - 1);
    localparam logic [CNTW-1:0] CNT_MAX   = CNTW'(W * NLANE);

    typedef struct packed {
        logic [CNTW-1:0] run;
        logic [CNTW-1:0] cnt;
        logic            stb;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [W-1:0]    diff;
    logic [CNTW-1:0] ones;
    logic [CNTW-1:0] sum;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.stb = 1'b0;
        diff      = rx_b ^ exp_b;
        ones      = '0;
        for (int i = 0; i < W; i++) ones = ones + CNTW'(diff[i]);
        sum = ((lane == '0) ? '0 : cnt_q.run) + ones;
        if (en) begin
            cnt_d.run = sum;
            if (lane == LANE_LAST) begin
                cnt_d.cnt = sum;
                cnt_d.stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign err_cnt = cnt_q.cnt;
    assign err_stb = cnt_q.stb;

    // R7: reported count never exceeds the number of parity bits
    a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |-> (err_cnt <= CNT_MAX));

    // R7: the strobe lasts a single cycle
    a_r7_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |=> !err_stb);

endmodule

// File: rtl/ms_bip24_engine.sv
module ms_bip24_engine
    import msb_pkg::*;
#(
    parameter int W       = 8,
    parameter int NCOL    = 270,
    parameter int NROW    = 9,
    parameter int OH_ROWS = 3,
    parameter int OH_COLS = 9,
    parameter int PAR_ROW = 4,
    parameter int NLANE   = 3,
    localparam int LW   = (NLANE > 1) ? $clog2(NLANE) : 1,
    localparam int CNTW = $clog2(W * NLANE + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_mode,
    input  logic            sof,
    input  logic            vld,
    input  logic [W-1:0]    din,
    output logic [W-1:0]    dout,
    output logic            dout_vld,
    output logic [CNTW-1:0] err_cnt,
    output logic            err_stb
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         vld;
    } out_t;

    out_t out_d, out_q;

    msb_mode_e               mode;
    logic                    act;
    slot_e                   slot;
    logic [LW-1:0]           lane;
    logic                    frame_end;
    logic [NLANE-1:0][W-1:0] held;
    logic                    held_ok;
    logic [W-1:0]            out_byte;
    logic                    take;
    logic                    chk_en;

    msb_frame_pos #(
        .NCOL(NCOL), .NROW(NROW), .OH_ROWS(OH_ROWS), .OH_COLS(OH_COLS),
        .PAR_ROW(PAR_ROW), .NLANE(NLANE)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .sof(sof), .vld(vld),
        .act(act), .slot(slot), .lane(lane), .frame_end(frame_end)
    );

    always_comb begin
        mode     = msb_mode_e'(chk_mode);
        out_byte = din;
        if (act && (slot == SLOT_PAR) && held_ok && (mode == MODE_GEN)) begin
            out_byte = held[lane];
        end
        take   = act && (slot != SLOT_SKIP);
        chk_en = act && (slot == SLOT_PAR) && held_ok && (mode == MODE_CHK);

        out_d.data = out_byte;
        out_d.vld  = vld;
    end

    msb_accum #(.W(W), .NLANE(NLANE)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(vld && sof), .take(take),
        .lane(lane), .din(out_byte), .fin(frame_end),
        .held(held), .held_ok(held_ok)
    );

    msb_errcnt #(.W(W), .NLANE(NLANE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(chk_en), .lane(lane),
        .rx_b(din), .exp_b(held[lane]),
        .err_cnt(err_cnt), .err_stb(err_stb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout     = out_q.data;
    assign dout_vld = out_q.vld;

    // R7: check mode never alters the stream
    a_r7_chk_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && chk_mode) |=> (dout == $past(din)));

    // R2 R4: only parity slots may be rewritten
    a_r4_other_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (slot != SLOT_PAR)) |=> (dout == $past(din)));

    // R8: bytes ahead of the first frame start pass unchanged
    a_r8_presync_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !act) |=> (dout == $past(din)));

    // R6: nothing to report before a complete frame
    a_r6_no_early_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !held_ok |=> !err_stb);

endmodule

// File: tb/ms_bip24_engine_tb.sv
`timescale 1ns/1ps
module ms_bip24_engine_tb;

    localparam int FBYTES = 2430;

    typedef struct packed {
        logic        mode;
        logic [7:0]  seed;
        logic        gaps;
        logic [23:0] flip;
        logic [11:0] nbytes;
    } vec_t;

    // one entry per frame sent; comments name the requirement each targets
    localparam vec_t VEC [10] = '{
        '{1'b0, 8'd1, 1'b0, 24'h000000, 12'd2430},  // R6 first frame, no insertion
        '{1'b0, 8'd2, 1'b1, 24'h000000, 12'd2430},  // R4 R8 gaps, insertion
        '{1'b0, 8'd3, 1'b0, 24'h000000, 12'd2430},  // R5 replaced bytes feed sum
        '{1'b0, 8'd4, 1'b0, 24'h000000, 12'd700},   // R9 truncated frame
        '{1'b0, 8'd5, 1'b0, 24'h000000, 12'd2430},  // R9 older result inserted
        '{1'b1, 8'd6, 1'b0, 24'h000000, 12'd2430},  // R7 clean, count 0
        '{1'b1, 8'd7, 1'b0, 24'h000001, 12'd2430},  // R7 one bit
        '{1'b1, 8'd8, 1'b1, 24'hFFFFFF, 12'd2430},  // R7 all 24 bits
        '{1'b1, 8'd9, 1'b0, 24'h800F01, 12'd2430},  // R7 six bits
        '{1'b0, 8'd10, 1'b0, 24'h000000, 12'd2430}  // R3 R4 back to generate
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_mode = 1'b0;
    logic       sof = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_vld;
    logic [4:0] err_cnt;
    logic       err_stb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit have = 1'b0;
    logic [2:0][7:0] par_prev = '0;

    always #10 clk = ~clk;

    ms_bip24_engine u_dut (
        .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode), .sof(sof), .vld(vld),
        .din(din), .dout(dout), .dout_vld(dout_vld),
        .err_cnt(err_cnt), .err_stb(err_stb)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int s, input int r, input int c);
        int x;
        x = s * 2654435 + r * 40503 + c * 9176 + 17;
        x = x ^ (x >>> 7) ^ (x >>> 13);
        return x[7:0];
    endfunction

    task automatic drive_byte(input logic [7:0] d, input bit s, input logic [7:0] e,
                              input bit e_stb, input logic [4:0] e_cnt, input string tag);
        @(negedge clk);
        vld = 1'b1; sof = s; din = d;
        @(posedge clk);
        #1;
        check(dout_vld === 1'b1 && dout === e, tag, "dout", {23'd0, dout_vld, dout}, {24'd1, e});
        check(err_stb === e_stb, "R7 R6", "err_stb", {31'd0, err_stb}, {31'd0, e_stb});
        if (e_stb) check(err_cnt === e_cnt, "R7", "err_cnt", {27'd0, err_cnt}, {27'd0, e_cnt});
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        vld = 1'b0; sof = 1'b0; din = 8'hA5;
        @(posedge clk);
        #1;
        check(dout_vld === 1'b0, "R8", "dout_vld idle", {31'd0, dout_vld}, 32'd0);
        check(err_stb === 1'b0, "R7", "err_stb idle", {31'd0, err_stb}, 32'd0);
    endtask

    task automatic send_frame(input vec_t v);
        logic [2:0][7:0] acc;
        acc = '0;
        chk_mode = v.mode;
        for (int i = 0; i < int'(v.nbytes); i++) begin
            int r;
            int c;
            logic [7:0] d;
            logic [7:0] e;
            bit ispar;
            bit e_stb;
            string tag;
            r = i / 270;
            c = i % 270;
            d = gen_byte(int'(v.seed), r, c);
            ispar = (r == 4) && (c < 3);
            e = d;
            tag = "R2 R4";
            if (ispar) begin
                if (v.mode) begin
                    if (have) d = par_prev[c] ^ v.flip[8*c +: 8];
                    e = d;
                    tag = "R7";
                end else if (have) begin
                    e = par_prev[c];
                    tag = "R3 R4 R5 R9";
                end else begin
                    tag = "R6";
                end
            end
            e_stb = v.mode && have && (r == 4) && (c == 2);
            drive_byte(d, i == 0, e, e_stb, 5'($countones(v.flip)), tag);
            if (!((r < 3) && (c < 9))) acc[c % 3] = acc[c % 3] ^ e;
            if (v.gaps && (c % 7 == 3)) idle_cycle();
        end
        if (int'(v.nbytes) == FBYTES) begin
            par_prev = acc;
            have = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b0; sof = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(dout_vld === 1'b0, "R1", "dout_vld", {31'd0, dout_vld}, 32'd0);
        check(err_stb === 1'b0, "R1", "err_stb", {31'd0, err_stb}, 32'd0);
        check(err_cnt === 5'd0, "R1", "err_cnt", {27'd0, err_cnt}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        have = 1'b0;
        @(posedge clk);
        #1;
        check(dout_vld === 1'b0 && err_stb === 1'b0, "R1", "after release",
              {30'd0, dout_vld, err_stb}, 32'd0);
    endtask

    initial begin
        do_reset();
        // R8: bytes before any frame start pass through untouched
        for (int k = 0; k < 5; k++) begin
            drive_byte(8'h30 + 8'(k), 1'b0, 8'h30 + 8'(k), 1'b0, 5'd0, "R8");
        end
        idle_cycle();
        for (int n = 0; n < 10; n++) send_frame(VEC[n]);
        idle_cycle();

        // R6: check mode right after reset reports nothing for the first frame
        do_reset();
        send_frame('{1'b1, 8'd21, 1'b0, 24'hFFFFFF, 12'd2430});
        // R7: then a single corrupted byte lane gives eight mismatched bits
        send_frame('{1'b1, 8'd22, 1'b0, 24'h0000FF, 12'd2430});
        idle_cycle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule